// File: doc/BRIEF.md
# Three-Wire Attenuator Programming Serializer

This block programs a digitally controlled attenuator over a three-wire link: a serial data line, a serial clock and a frame line. The frame line is high when the link is idle (load level) and low while bits are shifted in. The host presents a channel-address byte and an attenuation byte and pulses `start_i`. The block then sends the address byte and, right after it, the attenuation byte. Each byte goes out most significant bit first. When the word is complete the block raises the frame line, which makes the attenuator latch the word, and pulses `done_o`.

Bit timing comes from a compare counter. Each half of a serial clock period lasts `HALF_CLKS` system clocks. A bit slot is a low half followed by a high half. The data line changes only at the falling edge of the serial clock, so it is stable at every rising edge, where the attenuator samples it. After the last falling edge the frame line stays low for one more half-bit before it returns to the load level. A start request that arrives while a transfer is running is ignored.

Top module: `atten_ser_top`

## Requirements
- R1: After reset: `busy_o`=0, `frame_o`=1, `sclk_o`=0, `sdata_o`=0 and `done_o`=0.
- R2: A `start_i` that is high at a clock edge while `busy_o`=0 is accepted at that edge. `chan_i` and `level_i` are captured, and from that edge `busy_o`=1 and `frame_o`=0.
- R3: The 16 bits on `sdata_o` at the 16 rising edges of `sclk_o` are `chan_i` followed by `level_i`, each MSB first. For example, channel 0x5A and level 0x81 give 0101101010000001.
- R4: Count n system clocks after the accepting edge and let h = n / HALF_CLKS. While h < 32, `sclk_o` is 1 exactly when h is odd. Bit slot k (0 to 15) covers h = 2k and h = 2k+1, which gives 16 clock pulses.
- R5: `sdata_o` holds the value of bit slot h/2 for all of that slot. It changes only as `sclk_o` goes from 1 to 0, and never while `sclk_o` is high.
- R6: `frame_o` stays 0 from the accepting edge up to n = 33*HALF_CLKS. That is one half-bit after the final falling edge of `sclk_o`. At that point `frame_o` returns to 1 and `busy_o` falls.
- R7: `done_o` is high for exactly one cycle, the same cycle in which `busy_o` first reads 0 after a transfer.
- R8: `start_i` pulses while `busy_o`=1 are ignored. The waveforms on `sdata_o`, `sclk_o` and `frame_o` and the bits sent stay those of the transfer in progress.
- R9: While `busy_o`=0, `sdata_o`=0 and `sclk_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send a word |
| chan_i | input | 8 | Channel-address byte, sent first |
| level_i | input | 8 | Attenuation byte, sent second |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| sdata_o | output | 1 | Serial data, valid at rising edges of sclk_o |
| sclk_o | output | 1 | Serial clock, idle low |
| frame_o | output | 1 | Frame line: 1 = load (idle), 0 = shift |

## Verification
Every output is a register, so all results are counted from the edge that accepts `start_i`. After n system clocks the serial clock and data are given by half-bit index n / HALF_CLKS. The end of the transfer (`busy_o` low, `frame_o` high, `done_o` high) is due exactly 33*HALF_CLKS cycles after that edge, and `done_o` clears one cycle later. The bench samples on the falling system-clock edge, computes the expected output vector for each n from this formula, and compares every cycle. It also rebuilds the 16-bit word from `sdata_o` at each observed rising edge of `sclk_o`.

// File: rtl/atten_ser_pkg.sv
// Shared constants for the attenuator serializer.
// Assumes a fixed two-byte word: address byte, then value byte.
package atten_ser_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    // Half-bit slots: two per bit, plus one tail half before the latch.
    localparam int HALVES    = 2 * WORD_W + 1;
    localparam int HC_W      = $clog2(HALVES + 1);
endpackage

// File: rtl/atten_half_timer.sv
// Compare counter that marks the end of each half bit period.
// Assumes HALF_CLKS >= 1. Restart clears the count so that the first
// half begins exactly at the restart edge.
module atten_half_timer #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_q;

    // Compare: the half period ends when the count reaches its limit.
    assign tick = run && (cnt_q == LAST);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/atten_frame_seq.sv
// Sequencer for the half-bit slots. It drives busy, the frame line, the
// serial clock and done, and tells the shifter when to move to the next bit.
// Assumes one tick per half period from the timer while busy.
module atten_frame_seq
    import atten_ser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic tick,
    output logic busy,
    output logic frame,
    output logic sclk,
    output logic done,
    output logic shift_en
);
    localparam logic [HC_W-1:0] TAIL = HC_W'(HALVES - 1);

    logic [HC_W-1:0] half_q;

    // Move to the next bit at the end of every high half (the falling edge).
    assign shift_en = busy && tick && half_q[0] && (half_q != TAIL);

    // Step through the half-bit slots and produce the framing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            frame  <= 1'b1;
            sclk   <= 1'b0;
            done   <= 1'b0;
            half_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                frame  <= 1'b0;
                sclk   <= 1'b0;
                half_q <= '0;
            end else if (busy && tick) begin
                if (half_q == TAIL) begin
                    busy  <= 1'b0;
                    frame <= 1'b1;
                    sclk  <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    half_q <= half_q + 1'b1;
                    // Even slot ending -> high half starts; odd -> falling edge.
                    sclk   <= ~half_q[0];
                end
            end
        end
    end
endmodule

// File: rtl/atten_shifter.sv
// Shift register that holds the address and value bytes and presents the
// current bit, MSB first. Assumes the address byte is the upper half.
module atten_shifter
    import atten_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [BYTE_W-1:0] val_byte,
    input  logic              shift_en,
    input  logic              active,
    output logic              bit_out
);
    logic [WORD_W-1:0] word_q;

    // Present the current MSB only while a transfer runs.
    assign bit_out = active && word_q[WORD_W-1];

    // Load the word on accept; shift left at every serial falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= {addr_byte, val_byte};
        end else if (shift_en) begin
            word_q <= {word_q[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/atten_ser_top.sv
// Top of the three-wire attenuator programming serializer.
// Assumes start_i is synchronous to clk. Requests are ignored while busy.
module atten_ser_top
    import atten_ser_pkg::*;
#(
    parameter int HALF_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] chan_i,
    input  logic [BYTE_W-1:0] level_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              frame_o
);
    logic accept;
    logic tick;
    logic shift_en;

    // A request counts only when no transfer is running.
    assign accept = start_i && !busy_o;

    atten_half_timer #(.HALF_CLKS(HALF_CLKS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy_o),
        .tick    (tick)
    );

    atten_frame_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .tick     (tick),
        .busy     (busy_o),
        .frame    (frame_o),
        .sclk     (sclk_o),
        .done     (done_o),
        .shift_en (shift_en)
    );

    atten_shifter shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .addr_byte (chan_i),
        .val_byte  (level_i),
        .shift_en  (shift_en),
        .active    (busy_o),
        .bit_out   (sdata_o)
    );
endmodule

// File: rtl/atten_ser_chk.sv
// Property checker for the serializer, attached by bind.
module atten_ser_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic sdata_o,
    input logic sclk_o,
    input logic frame_o
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !frame_o));
    // R5
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && frame_o));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !sdata_o));
    // R6
    frame_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o || $rose(sclk_o)) |-> !frame_o);
endmodule

bind atten_ser_top atten_ser_chk chk_i (.*);

// File: tb/atten_ser_top_tb_top.sv
module atten_ser_top_tb_top;
    localparam int H = 3;
    localparam int END_N = 33 * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] chan_i = '0;
    logic [7:0] level_i = '0;
    logic busy_o, done_o, sdata_o, sclk_o, frame_o;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    atten_ser_top #(.HALF_CLKS(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .level_i(level_i), .busy_o(busy_o), .done_o(done_o),
        .sdata_o(sdata_o), .sclk_o(sclk_o), .frame_o(frame_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {busy, frame, sclk, sdata, done} n cycles after the accepting edge.
    function automatic logic [4:0] exp_vec(input int n, input logic [15:0] w);
        int h;
        h = n / H;
        if (n < END_N) begin
            if (h < 32) return {1'b1, 1'b0, h[0], w[15 - h / 2], 1'b0};
            return 5'b10000;
        end
        if (n == END_N) return 5'b01001;
        return 5'b01000;
    endfunction

    task automatic run_xfer(input logic [7:0] c, input logic [7:0] l, input bit interfere);
        logic [15:0] w;
        logic [15:0] got;
        logic prev_sclk;
        int errs;
        w = {c, l};
        got = '0;
        prev_sclk = 1'b0;
        errs = 0;
        @(negedge clk);
        start_i = 1'b1; chan_i = c; level_i = l;
        for (int n = 0; n <= END_N + 1; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            // R4 R5 R6 R7 cycle-exact output vector
            if ({busy_o, frame_o, sclk_o, sdata_o, done_o} !== exp_vec(n, w)) errs++;
            if (sclk_o && !prev_sclk) got = {got[14:0], sdata_o};
            prev_sclk = sclk_o;
            if (interfere && (n == 7 || n == 40)) begin
                // R8: requests while busy must be ignored
                start_i = 1'b1; chan_i = ~c; level_i = ~l;
            end
        end
        start_i = 1'b0;
        check(interfere ? "R8 waveform under ignored start" : "R4 R5 R6 R7 waveform mismatches",
              errs, 0);
        check(interfere ? "R8 word under ignored start" : "R3 word sent", {16'd0, got}, {16'd0, w});
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, sampled before any start
        check("R1 busy", busy_o, 0);
        check("R1 frame", frame_o, 1);
        check("R1 sclk/sdata/done", {sclk_o, sdata_o, done_o}, 0);
        // R9 idle outputs stay quiet over several cycles
        repeat (5) begin
            @(negedge clk);
            check("R9 idle quiet", {busy_o, sclk_o, sdata_o}, 0);
        end
        // R2 start accepted: busy high and frame low one edge later
        @(negedge clk);
        start_i = 1'b1; chan_i = 8'h5A; level_i = 8'h81;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 accept", {busy_o, frame_o}, 2'b10);
        repeat (END_N + 3) @(negedge clk);
        // R3 directed example and corners
        run_xfer(8'h5A, 8'h81, 1'b0);
        run_xfer(8'h00, 8'hFF, 1'b0);
        run_xfer(8'hFF, 8'h00, 1'b0);
        run_xfer(8'h80, 8'h01, 1'b1);
        for (int i = 0; i < 10; i++) begin
            run_xfer(8'($urandom), 8'($urandom), 1'($urandom));
        end
        @(negedge clk);
        check("R9 idle after transfers", {busy_o, frame_o, sclk_o, sdata_o, done_o}, 5'b01000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule